// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line-Break Detection

This block turns an asynchronous serial line into parallel characters. A sample enable pulses at 16 or 64 times the bit rate; the line input passes through a synchronizer and the receiver waits for a falling edge. It confirms the start bit half a bit later and then samples each later bit at its centre. A character can have 5 to 8 data bits, with an optional parity bit and one stop bit. The finished character goes to a holding register, which raises a ready flag for the host.

Error flags report parity mismatches, missing stop bits and characters that arrive before the previous one was read. A stop bit found at space does not lose alignment: if the space lasts into the next bit interval, the receiver takes it as the start bit of the next character.

A line held at space for a whole character is a break. A break gives exactly one null character with the framing flag set, and it raises a level output. That output stays high until the line returns to mark. Dropping the receive enable abandons any partial character and clears the flags.

Top module: `serial_rx_core`

## Requirements
- R1: The line input passes through a two-flop synchronizer before any use. After a falling edge, the receiver samples again 8 sample ticks later (32 at the 64X rate). If the line is high at that point, nothing is delivered and the receiver goes back to looking for a start bit.
- R2: After a valid start bit, one bit is sampled every 16 ticks (`fast_rate`=0) or every 64 ticks (`fast_rate`=1). Data bits arrive least significant first; there are 5, 6, 7 or 8 of them for `char_len` = 00, 01, 10 or 11. An optional parity bit follows when `par_en`=1, then one stop bit.
- R3: When the character has fewer than 8 bits, the unused high bits of `rx_data` read as zero.
- R4: `par_even`=1 selects even parity and 0 selects odd parity, counted over the data bits plus the parity bit. A mismatch sets `par_err`.
- R5: A stop bit sampled at space still delivers the character and sets `frm_err`. If the line is still at space one bit time later, that space is taken as a valid start bit, so a character that follows at once is received correctly.
- R6: A line at space through every data bit, the parity bit and the stop bit is a break. It delivers exactly one 0x00 character, sets `frm_err` and sets `brk_det`. No further character is taken until the line goes back to mark.
- R7: `brk_det` falls on the first sample tick that sees the synchronized line at mark.
- R8: `rx_ready` sets when a character enters the holding register and clears on `rd_strobe`.
- R9: If a character is delivered while `rx_ready` is still set and not being read in the same cycle, `ovr_err` sets and `rx_data` holds the newer character.
- R10: `err_clr` clears `par_err`, `frm_err` and `ovr_err`. It leaves `rx_ready` unchanged.
- R11: While `rx_en` is low, `rx_ready`, all error flags and `brk_det` are cleared, and any partly received character is dropped without being delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| samp_en | input | 1 | Oversampling tick, 16X or 64X the bit rate |
| rxd | input | 1 | Serial line, high is mark |
| rx_en | input | 1 | Receiver enable |
| fast_rate | input | 1 | 0: 16X tick, 1: 64X tick |
| char_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 even, 0 odd parity |
| rd_strobe | input | 1 | Host read of the holding register |
| err_clr | input | 1 | Clear the error flags |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | Character waiting |
| par_err | output | 1 | Parity error flag |
| frm_err | output | 1 | Framing error flag |
| ovr_err | output | 1 | Overrun flag |
| brk_det | output | 1 | Break detected, level output |

## Verification
The assertions check the holding-register rules on every cycle:
- a delivery raises ready;
- a read clears it;
- a delivery onto an unread character records an overrun;
- a break loads a zero character with the framing flag;
- disable and error-clear wipe the flags;
- a start bit rejected at mid-bit returns the framer to idle;
- short characters have their high bits clear.

Only the bench's scenarios can show things that depend on the line's timing: bit-centre sampling at both rates, parity polarity, resynchronization after a missing stop bit, break delivering a single character and then waiting for mark, and a partial character being dropped by disable.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  typedef enum logic [2:0] {
    ST_MARK,
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_RESYNC
  } rx_state_t;

  // index of the last data bit for a length code (5..8 bits)
  function automatic logic [2:0] last_bit_idx(input logic [1:0] len);
    return 3'd4 + {1'b0, len};
  endfunction

  // bits arrive LSB first into the top of the shifter; move them down
  function automatic logic [7:0] align_char(input logic [7:0] sh,
                                            input logic [1:0] len);
    return sh >> (2'd3 - len);
  endfunction

  // 1 when the received parity bit disagrees with the selected sense
  function automatic logic parity_bad(input logic [7:0] d, input logic p,
                                      input logic even);
    return (^d) ^ p ^ ~even;
  endfunction

endpackage

// File: rtl/rxb_sync.sv
module rxb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '1;
        else        pipe <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rxb_frame.sv
module rxb_frame
  import rxb_pkg::*;
#(
  parameter int unsigned BASE_OVS = 16,
  parameter int unsigned FAST_OVS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd_s,
  input  logic       rx_en,
  input  logic       fast_rate,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_even,
  output logic       deliver,
  output logic [7:0] char_out,
  output logic       pe_hit,
  output logic       fe_hit,
  output logic       brk_hit,
  output logic       mark_seen
);
  localparam int unsigned CNT_W = $clog2(FAST_OVS);
  localparam logic [CNT_W-1:0] B_HALF = CNT_W'(BASE_OVS / 2 - 1);
  localparam logic [CNT_W-1:0] F_HALF = CNT_W'(FAST_OVS / 2 - 1);
  localparam logic [CNT_W-1:0] B_FULL = CNT_W'(BASE_OVS - 1);
  localparam logic [CNT_W-1:0] F_FULL = CNT_W'(FAST_OVS - 1);

  rx_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bidx;
  logic [7:0]       shreg;
  logic             pbit;

  logic [CNT_W-1:0] half_lim, full_lim;
  logic             at_mid, at_bit, all_space;
  logic [7:0]       aligned;

  assign half_lim = fast_rate ? F_HALF : B_HALF;
  assign full_lim = fast_rate ? F_FULL : B_FULL;
  assign at_mid   = tick && (state == ST_START) && (cnt == half_lim);
  assign at_bit   = tick && (cnt == full_lim) &&
                    (state == ST_DATA || state == ST_PAR ||
                     state == ST_STOP || state == ST_RESYNC);

  assign aligned   = align_char(shreg, char_len);
  assign all_space = (shreg == 8'h00) && !(par_en && pbit) && !rxd_s;
  assign deliver   = at_bit && (state == ST_STOP);
  assign brk_hit   = deliver && all_space;
  assign fe_hit    = deliver && !rxd_s;
  assign pe_hit    = deliver && par_en && !all_space &&
                     parity_bad(aligned, pbit, par_even);
  assign char_out  = brk_hit ? 8'h00 : aligned;
  assign mark_seen = tick && (state == ST_MARK) && rxd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_MARK;
      cnt   <= '0;
      bidx  <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
    end else if (!rx_en) begin
      state <= ST_MARK;
      cnt   <= '0;
      bidx  <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
      unique case (state)
        ST_MARK: if (rxd_s) state <= ST_IDLE;
        ST_IDLE: if (!rxd_s) begin
          state <= ST_START;
          cnt   <= '0;
        end
        ST_START: if (at_mid) begin
          cnt <= '0;
          if (rxd_s) state <= ST_IDLE;
          else begin
            state <= ST_DATA;
            bidx  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
          end
        end
        ST_DATA: if (at_bit) begin
          cnt   <= '0;
          shreg <= {rxd_s, shreg[7:1]};
          bidx  <= bidx + 1'b1;
          if (bidx == last_bit_idx(char_len))
            state <= par_en ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (at_bit) begin
          cnt   <= '0;
          pbit  <= rxd_s;
          state <= ST_STOP;
        end
        ST_STOP: if (at_bit) begin
          cnt <= '0;
          if (all_space)  state <= ST_MARK;
          else if (!rxd_s) state <= ST_RESYNC;
          else             state <= ST_IDLE;
        end
        ST_RESYNC: if (at_bit) begin
          cnt <= '0;
          if (rxd_s) state <= ST_IDLE;
          else begin
            state <= ST_DATA;
            bidx  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
          end
        end
        default: state <= ST_MARK;
      endcase
    end
  end

  // R1: a start bit found at mark at its centre goes back to the search
  assert_false_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (at_mid && rxd_s && rx_en) |=> (state == ST_IDLE));

  // R6: after a break, the framer waits for mark
  assert_break_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_hit && rx_en) |=> (state == ST_MARK));

endmodule

// File: rtl/rxb_hold.sv
module rxb_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       deliver,
  input  logic [7:0] char_in,
  input  logic       pe_hit,
  input  logic       fe_hit,
  input  logic       brk_hit,
  input  logic       mark_seen,
  input  logic       rd_strobe,
  input  logic       err_clr,
  input  logic [1:0] char_len,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       par_err,
  output logic       frm_err,
  output logic       ovr_err,
  output logic       brk_det
);
  logic ovr_hit;
  assign ovr_hit = deliver && rx_ready && !rd_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_ready <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      ovr_err  <= 1'b0;
      brk_det  <= 1'b0;
    end else if (!rx_en) begin
      rx_ready <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      ovr_err  <= 1'b0;
      brk_det  <= 1'b0;
    end else begin
      if (deliver) rx_data <= char_in;
      if (deliver)        rx_ready <= 1'b1;
      else if (rd_strobe) rx_ready <= 1'b0;
      par_err <= (par_err && !err_clr) || pe_hit;
      frm_err <= (frm_err && !err_clr) || fe_hit;
      ovr_err <= (ovr_err && !err_clr) || ovr_hit;
      if (brk_hit)        brk_det <= 1'b1;
      else if (mark_seen) brk_det <= 1'b0;
    end
  end

  assert_ready_on_delivery_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && rx_en) |=> rx_ready);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !deliver) |=> !rx_ready);

  assert_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && rx_en && rx_ready && !rd_strobe) |=> ovr_err);

  assert_break_null_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_hit && rx_en) |=> (brk_det && rx_data == 8'h00 && frm_err));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && rx_en && char_len == 2'b00) |=> (rx_data[7:5] == 3'b000));

  assert_errclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !deliver) |=> (!par_err && !frm_err && !ovr_err));

  assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_ready && !par_err && !frm_err && !ovr_err && !brk_det));

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int unsigned BASE_OVS    = 16,
  parameter int unsigned FAST_OVS    = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       samp_en,
  input  logic       rxd,
  input  logic       rx_en,
  input  logic       fast_rate,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       rd_strobe,
  input  logic       err_clr,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       par_err,
  output logic       frm_err,
  output logic       ovr_err,
  output logic       brk_det
);
  logic       rxd_s;
  logic       deliver, pe_hit, fe_hit, brk_hit, mark_seen;
  logic [7:0] char_w;

  rxb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
  );

  rxb_frame #(.BASE_OVS(BASE_OVS), .FAST_OVS(FAST_OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(samp_en), .rxd_s(rxd_s), .rx_en(rx_en),
    .fast_rate(fast_rate), .char_len(char_len), .par_en(par_en),
    .par_even(par_even), .deliver(deliver), .char_out(char_w),
    .pe_hit(pe_hit), .fe_hit(fe_hit), .brk_hit(brk_hit), .mark_seen(mark_seen)
  );

  rxb_hold u_hold (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .deliver(deliver),
    .char_in(char_w), .pe_hit(pe_hit), .fe_hit(fe_hit), .brk_hit(brk_hit),
    .mark_seen(mark_seen), .rd_strobe(rd_strobe), .err_clr(err_clr),
    .char_len(char_len), .rx_data(rx_data), .rx_ready(rx_ready),
    .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err), .brk_det(brk_det)
  );
endmodule

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       samp_en = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_en = 1'b0;
  logic       fast_rate = 1'b0;
  logic [1:0] char_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       rd_strobe = 1'b0;
  logic       err_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, par_err, frm_err, ovr_err, brk_det;

  int n_chk = 0;
  int n_fail = 0;
  int bitclk = 32;
  bit done = 0;

  serial_rx_core uut (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rxd(rxd), .rx_en(rx_en),
    .fast_rate(fast_rate), .char_len(char_len), .par_en(par_en),
    .par_even(par_even), .rd_strobe(rd_strobe), .err_clr(err_clr),
    .rx_data(rx_data), .rx_ready(rx_ready), .par_err(par_err),
    .frm_err(frm_err), .ovr_err(ovr_err), .brk_det(brk_det)
  );

  always #2 clk = ~clk;

  // sample tick every second clock
  initial forever begin
    @(negedge clk);
    samp_en = ~samp_en;
  end

  // fields: len[19:18] par[17] even[16] fast[15] flip[14] badstop[13] data[7:0]
  localparam logic [19:0] VEC [8] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 8'hA5},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 8'hFF},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 8'h35},
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 8'h2A},
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 8'hC3},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 8'h5A},
    {2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0, 8'h13},
    {2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 8'h7F}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_rate(input logic f);
    fast_rate = f;
    bitclk = f ? 128 : 32;
  endtask

  task automatic line(input logic b, input int nbits);
    rxd = b;
    repeat (nbits * bitclk) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] d, input logic flip, input logic stopv,
                       input int idle_bits);
    logic [7:0] m;
    m = d & (8'hFF >> (2'd3 - char_len));
    line(1'b0, 1);
    for (int k = 0; k < 5 + int'(char_len); k++) line(d[k], 1);
    if (par_en) line((^m) ^ ~par_even ^ flip, 1);
    line(stopv, 1);
    if (idle_bits > 0) line(1'b1, idle_bits);
  endtask

  task automatic pulse_rd();
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // reset state
    check("reset rx_ready R8", rx_ready, 0);
    check("reset flags R10", {par_err, frm_err, ovr_err}, 0);
    check("reset brk_det R7", brk_det, 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    line(1'b1, 2);

    // vector table: R2 R3 R4 R5 R8
    for (int i = 0; i < 8; i++) begin
      logic [7:0] exp_d;
      char_len = VEC[i][19:18];
      par_en   = VEC[i][17];
      par_even = VEC[i][16];
      set_rate(VEC[i][15]);
      line(1'b1, 1);
      frame(VEC[i][7:0], VEC[i][14], ~VEC[i][13], 2);
      exp_d = VEC[i][7:0] & (8'hFF >> (2'd3 - char_len));
      check($sformatf("vec%0d data R2 R3", i), rx_data, exp_d);
      check($sformatf("vec%0d ready R8", i), rx_ready, 1);
      check($sformatf("vec%0d parity R4", i), par_err, VEC[i][17] & VEC[i][14]);
      check($sformatf("vec%0d framing R5", i), frm_err, VEC[i][13]);
      check($sformatf("vec%0d overrun R9", i), ovr_err, 0);
      pulse_rd();
      check($sformatf("vec%0d read R8", i), rx_ready, 0);
      pulse_clr();
    end

    set_rate(1'b0);
    char_len = 2'd3; par_en = 1'b0;

    // false start: low for 4 ticks only
    rxd = 1'b0; repeat (8) @(negedge clk);
    line(1'b1, 4);
    check("false start ignored R1", rx_ready, 0);
    frame(8'h96, 1'b0, 1'b1, 2);
    check("after false start R1", rx_data, 8'h96);
    pulse_rd();

    // overrun
    frame(8'h11, 1'b0, 1'b1, 1);
    frame(8'h22, 1'b0, 1'b1, 2);
    check("overrun flag R9", ovr_err, 1);
    check("overrun newest R9", rx_data, 8'h22);
    pulse_clr();
    check("err_clr overrun R10", ovr_err, 0);
    check("err_clr keeps ready R10", rx_ready, 1);
    pulse_rd();

    // missing stop bit followed at once by the next start bit
    frame(8'h3C, 1'b0, 1'b0, 0);
    frame(8'hC5, 1'b0, 1'b1, 2);
    check("resync data R5", rx_data, 8'hC5);
    check("resync framing R5", frm_err, 1);
    pulse_rd();
    pulse_clr();

    // break
    line(1'b0, 12);
    check("break ready R6", rx_ready, 1);
    check("break data R6", rx_data, 0);
    check("break framing R6", frm_err, 1);
    check("break output R6", brk_det, 1);
    pulse_rd();
    line(1'b0, 10);
    check("break single char R6", rx_ready, 0);
    check("break held R7", brk_det, 1);
    rxd = 1'b1; repeat (8) @(negedge clk);
    check("break release R7", brk_det, 0);
    pulse_clr();
    line(1'b1, 1);
    frame(8'h4B, 1'b0, 1'b1, 2);
    check("after break R6", rx_data, 8'h4B);
    pulse_rd();

    // disable: flags cleared and partial character dropped
    par_en = 1'b1; par_even = 1'b0;
    frame(8'h81, 1'b1, 1'b1, 1);
    check("pre-disable parity R4", par_err, 1);
    line(1'b0, 1);
    line(1'b1, 2);
    rx_en = 1'b0; repeat (2) @(negedge clk);
    check("disable ready R11", rx_ready, 0);
    check("disable flags R11", {par_err, frm_err, ovr_err}, 0);
    rx_en = 1'b1;
    line(1'b1, 10);
    check("partial dropped R11", rx_ready, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule